// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Controller

This block sits between instruction decode and the execution pipes of a two-wide in-order core. It keeps a two-entry issue window holding the two oldest decoded instructions and decides every cycle whether both may leave together, only the older one may leave, or nothing may leave. Each instruction arrives with a two-bit execution group, a step count used only by multi-step instructions, a flag saying that it depends on the instruction just before it in program order, and an opaque tag that is passed to the issue outputs.

When the pair is not compatible, the older instruction issues alone. The younger one moves down to the first slot and pairs with the next instruction fetched. This move is reported on `recombine`. A multi-step instruction holds a resource lock for the rest of its step count. While the lock is held, nothing issues, and any instruction waiting in the window is stalled. Every cycle in which a held instruction cannot leave is reported on `stall`. New instructions enter through a two-lane valid/ready handshake. A lane is accepted only into a slot that the issue decision of the same cycle has freed.

Top module: `dual_issue_pairer`

## Requirements
- R1: After reset the window is empty: `issue0`, `issue1`, `recombine` and `stall` are low, and `in_ready` is 2'b11.
- R2: Group encoding: 2'b00 is integer execute, 2'b01 is load/store, 2'b10 is multi-step. An execute and a load/store instruction, in either order and with the younger dependency flag low, issue in the same cycle with `stall` low.
- R3: Two instructions of the same group (execute with execute, or load/store with load/store) do not pair. The older one issues alone, `recombine` and `stall` are high for that cycle, and the younger one issues from slot 0 in the following cycle.
- R4: When the younger instruction's dependency flag is high, it does not issue alongside the older one, even when the groups are compatible.
- R5: A multi-step instruction never pairs, whether it sits in slot 0 or in slot 1.
- R6: A multi-step instruction with step count N > 1 blocks all issue for the N-1 cycles after its own issue cycle. `stall` is high in those cycles whenever the window holds an instruction.
- R7: When the lock releases, the instruction that was held issues at once and may pair with an instruction that entered during the lock.
- R8: `in_ready[0]` is high when at least one slot is free after this cycle's issue, and `in_ready[1]` is high when both slots are free. Lane 1 is taken only together with lane 0.
- R9: Issue keeps program order. `issue1` is never high without `issue0`, and `issue_tag0` is the oldest instruction.
- R10: A multi-step instruction with step count 0 or 1 takes no lock, so the next instruction may issue in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 2 | Lane valid; bit 0 is the older lane |
| in_ready | output | 2 | Lane accepted this cycle when valid |
| in_grp0 | input | 2 | Group of lane 0 |
| in_step0 | input | STEP_W | Step count of lane 0 |
| in_dep0 | input | 1 | Lane 0 depends on its predecessor |
| in_tag0 | input | TAG_W | Tag of lane 0 |
| in_grp1 | input | 2 | Group of lane 1 |
| in_step1 | input | STEP_W | Step count of lane 1 |
| in_dep1 | input | 1 | Lane 1 depends on lane 0 |
| in_tag1 | input | TAG_W | Tag of lane 1 |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| issue_tag0 | output | TAG_W | Tag of slot 0 |
| issue_tag1 | output | TAG_W | Tag of slot 1 |
| recombine | output | 1 | Slot 1 moves to slot 0 for re-pairing |
| stall | output | 1 | A held instruction could not issue |

## Verification
The pairing decision is tried with execute+execute, load/store+load/store, execute+load/store, load/store+execute, a compatible pair with the dependency flag set, and multi-step instructions in either slot. Together these separate a group rule from a dependency rule, and an order-sensitive check from a symmetric one. The lock is tried with step counts of four, one and zero. This shows the exact release cycle and the no-lock boundary. One instruction pushed during the lock shows that the held instruction re-pairs once the lock is gone. In the serial cases, the ready value and a push made in the same cycle check that slots are refilled at the position that issue freed.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    GRP_EX  = 2'b00,
    GRP_LS  = 2'b01,
    GRP_MS  = 2'b10,
    GRP_RSV = 2'b11
  } grp_e;
endpackage

// File: rtl/pair_rules.sv
module pair_rules
  import pair_pkg::*;
(
  input  logic [1:0] grp_old,
  input  logic [1:0] grp_young,
  input  logic       dep_young,
  output logic       pair_ok
);
  logic ex_ls;
  logic ls_ex;

  always_comb begin
    ex_ls   = (grp_old == GRP_EX) && (grp_young == GRP_LS);
    ls_ex   = (grp_old == GRP_LS) && (grp_young == GRP_EX);
    pair_ok = (ex_ls || ls_ex) && !dep_young;
  end
endmodule

// File: rtl/pair_lock.sv
module pair_lock #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] start_steps,
  output logic              busy
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  logic [STEP_W-1:0] cnt_q;
  logic [STEP_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = start || busy;
    cnt_d  = cnt_q;
    if (start)
      cnt_d = (start_steps > ONE) ? start_steps - ONE : '0;
    else if (busy)
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  assert_lock_counts_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/pair_window.sv
module pair_window #(
  parameter int STEP_W = 3,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss0,
  input  logic              iss1,
  input  logic [1:0]        in_valid,
  input  logic [1:0]        lane_grp  [2],
  input  logic [STEP_W-1:0] lane_step [2],
  input  logic              lane_dep  [2],
  input  logic [TAG_W-1:0]  lane_tag  [2],
  output logic [1:0]        in_ready,
  output logic [1:0]        v_q,
  output logic [1:0]        grp_q     [2],
  output logic [STEP_W-1:0] stp_q     [2],
  output logic [TAG_W-1:0]  tag_q     [2],
  output logic              dep1_q
);
  logic [1:0] rem;
  logic       acc0, acc1, shift;
  logic       ld0, ld1, sel1_lane1;
  logic [1:0] v_d;

  always_comb begin
    if (!iss0)      rem = {1'b0, v_q[0]} + {1'b0, v_q[1]};
    else if (!iss1) rem = {1'b0, v_q[1]};
    else            rem = 2'd0;
    in_ready[0] = (rem != 2'd2);
    in_ready[1] = (rem == 2'd0);
    acc0  = in_valid[0] && in_ready[0];
    acc1  = in_valid[1] && in_valid[0] && in_ready[1];
    shift = iss0 && !iss1 && v_q[1];
    ld0   = shift || ((rem == 2'd0) && acc0);
    ld1   = ((rem == 2'd1) && acc0) || ((rem == 2'd0) && acc1);
    sel1_lane1 = (rem == 2'd0);
    v_d[0] = (rem != 2'd0) || acc0;
    v_d[1] = (rem == 2'd2) || ((rem == 2'd1) && acc0) || ((rem == 2'd0) && acc1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      v_q <= '0;
    else
      v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (ld0) begin
      if (shift) begin
        grp_q[0] <= grp_q[1];
        stp_q[0] <= stp_q[1];
        tag_q[0] <= tag_q[1];
      end else begin
        grp_q[0] <= lane_grp[0];
        stp_q[0] <= lane_step[0];
        tag_q[0] <= lane_tag[0];
      end
    end
    if (ld1) begin
      if (sel1_lane1) begin
        grp_q[1] <= lane_grp[1];
        stp_q[1] <= lane_step[1];
        tag_q[1] <= lane_tag[1];
        dep1_q   <= lane_dep[1];
      end else begin
        grp_q[1] <= lane_grp[0];
        stp_q[1] <= lane_step[0];
        tag_q[1] <= lane_tag[0];
        dep1_q   <= lane_dep[0];
      end
    end
  end

  assert_window_packed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    v_q[1] |-> v_q[0]);
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import pair_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        in_valid,
  output logic [1:0]        in_ready,
  input  logic [1:0]        in_grp0,
  input  logic [STEP_W-1:0] in_step0,
  input  logic              in_dep0,
  input  logic [TAG_W-1:0]  in_tag0,
  input  logic [1:0]        in_grp1,
  input  logic [STEP_W-1:0] in_step1,
  input  logic              in_dep1,
  input  logic [TAG_W-1:0]  in_tag1,
  output logic              issue0,
  output logic              issue1,
  output logic [TAG_W-1:0]  issue_tag0,
  output logic [TAG_W-1:0]  issue_tag1,
  output logic              recombine,
  output logic              stall
);
  logic [1:0]        lane_grp  [2];
  logic [STEP_W-1:0] lane_step [2];
  logic              lane_dep  [2];
  logic [TAG_W-1:0]  lane_tag  [2];
  logic [1:0]        v_q;
  logic [1:0]        grp_q [2];
  logic [STEP_W-1:0] stp_q [2];
  logic [TAG_W-1:0]  tag_q [2];
  logic              dep1_q;
  logic              pair_ok, busy, ms_start;

  always_comb begin
    lane_grp[0]  = in_grp0;  lane_grp[1]  = in_grp1;
    lane_step[0] = in_step0; lane_step[1] = in_step1;
    lane_dep[0]  = in_dep0;  lane_dep[1]  = in_dep1;
    lane_tag[0]  = in_tag0;  lane_tag[1]  = in_tag1;
  end

  pair_window #(.STEP_W(STEP_W), .TAG_W(TAG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .iss0(issue0), .iss1(issue1),
    .in_valid(in_valid), .lane_grp(lane_grp), .lane_step(lane_step),
    .lane_dep(lane_dep), .lane_tag(lane_tag), .in_ready(in_ready),
    .v_q(v_q), .grp_q(grp_q), .stp_q(stp_q), .tag_q(tag_q), .dep1_q(dep1_q)
  );

  pair_rules u_rules (
    .grp_old(grp_q[0]), .grp_young(grp_q[1]), .dep_young(dep1_q), .pair_ok(pair_ok)
  );

  pair_lock #(.STEP_W(STEP_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(ms_start), .start_steps(stp_q[0]), .busy(busy)
  );

  always_comb begin
    issue0     = v_q[0] && !busy;
    issue1     = issue0 && v_q[1] && pair_ok;
    ms_start   = issue0 && (grp_q[0] == GRP_MS);
    issue_tag0 = tag_q[0];
    issue_tag1 = tag_q[1];
    recombine  = issue0 && v_q[1] && !issue1;
    stall      = (v_q[0] && busy) || (v_q[1] && !issue1);
  end

  assert_slot1_needs_slot0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> issue0);
  assert_no_same_group_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> (grp_q[0] != grp_q[1]));
  assert_dep_blocks_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> !dep1_q);
  assert_ms_never_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> (grp_q[0] != GRP_MS && grp_q[1] != GRP_MS));
  assert_ms_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_start && stp_q[0] > STEP_W'(1)) |=> !issue0);
endmodule

// File: tb/dual_issue_pairer_test.sv
module dual_issue_pairer_test;
  localparam int CLK_P  = 10;
  localparam int STEP_W = 3;
  localparam int TAG_W  = 8;
  localparam logic [1:0] EX = 2'b00, LS = 2'b01, MS = 2'b10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] in_valid, in_ready;
  logic [1:0] in_grp0, in_grp1;
  logic [STEP_W-1:0] in_step0, in_step1;
  logic in_dep0, in_dep1;
  logic [TAG_W-1:0] in_tag0, in_tag1;
  logic issue0, issue1, recombine, stall;
  logic [TAG_W-1:0] issue_tag0, issue_tag1;
  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_issue_pairer #(.STEP_W(STEP_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_grp0(in_grp0), .in_step0(in_step0), .in_dep0(in_dep0), .in_tag0(in_tag0),
    .in_grp1(in_grp1), .in_step1(in_step1), .in_dep1(in_dep1), .in_tag1(in_tag1),
    .issue0(issue0), .issue1(issue1), .issue_tag0(issue_tag0), .issue_tag1(issue_tag1),
    .recombine(recombine), .stall(stall)
  );

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic idle_in();
    in_valid = 2'b00;
    in_grp0 = EX; in_step0 = '0; in_dep0 = 1'b0; in_tag0 = '0;
    in_grp1 = EX; in_step1 = '0; in_dep1 = 1'b0; in_tag1 = '0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    idle_in();
    #1;
  endtask

  task automatic push2(input logic [1:0] g0, input logic [STEP_W-1:0] s0, input logic [TAG_W-1:0] t0,
                       input logic [1:0] g1, input logic [STEP_W-1:0] s1, input logic d1,
                       input logic [TAG_W-1:0] t1);
    in_valid = 2'b11;
    in_grp0 = g0; in_step0 = s0; in_tag0 = t0; in_dep0 = 1'b0;
    in_grp1 = g1; in_step1 = s1; in_tag1 = t1; in_dep1 = d1;
  endtask

  task automatic push1(input logic [1:0] g0, input logic [STEP_W-1:0] s0, input logic [TAG_W-1:0] t0);
    in_valid = 2'b01;
    in_grp0 = g0; in_step0 = s0; in_tag0 = t0; in_dep0 = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) next_cycle();
  endtask

  task automatic t_reset();
    chk("R1 issue0", issue0, 0);
    chk("R1 issue1", issue1, 0);
    chk("R1 recombine", recombine, 0);
    chk("R1 stall", stall, 0);
    chk("R1 in_ready", in_ready, 3);
  endtask

  task automatic t_ex_ex();
    push2(EX, 0, 8'd1, EX, 0, 1'b0, 8'd2);
    next_cycle();
    push1(LS, 0, 8'd3);
    #1;
    chk("R3 ex-ex issue0", issue0, 1);
    chk("R3 ex-ex issue1", issue1, 0);
    chk("R9 ex-ex tag0", issue_tag0, 1);
    chk("R3 recombine", recombine, 1);
    chk("R3 stall", stall, 1);
    chk("R8 ready one free", in_ready, 1);
    next_cycle();
    chk("R3 repair issue0", issue0, 1);
    chk("R3 repair issue1", issue1, 1);
    chk("R9 repair tag0", issue_tag0, 2);
    chk("R9 repair tag1", issue_tag1, 3);
    chk("R2 repair stall", stall, 0);
    chk("R8 ready two free", in_ready, 3);
    drain();
  endtask

  task automatic t_pair(input logic [1:0] g0, input logic [1:0] g1, input int exp_pair, input string tg);
    push2(g0, 0, 8'd40, g1, 0, 1'b0, 8'd41);
    next_cycle();
    chk({tg, " issue0"}, issue0, 1);
    chk({tg, " issue1"}, issue1, exp_pair);
    chk({tg, " stall"}, stall, exp_pair ? 0 : 1);
    next_cycle();
    if (!exp_pair) begin
      chk({tg, " second issue0"}, issue0, 1);
      chk({tg, " second tag0"}, issue_tag0, 41);
    end else begin
      chk({tg, " empty after"}, issue0, 0);
    end
    drain();
  endtask

  task automatic t_dep();
    push2(EX, 0, 8'd60, LS, 0, 1'b1, 8'd61);
    next_cycle();
    chk("R4 dep issue1", issue1, 0);
    chk("R4 dep recombine", recombine, 1);
    next_cycle();
    chk("R4 dep younger tag0", issue_tag0, 61);
    chk("R4 dep younger issue0", issue0, 1);
    drain();
  endtask

  task automatic t_ms_lock();
    push2(MS, 3'd4, 8'd10, EX, 0, 1'b0, 8'd11);
    next_cycle();
    chk("R5 ms issue0", issue0, 1);
    chk("R5 ms issue1", issue1, 0);
    chk("R9 ms tag0", issue_tag0, 10);
    next_cycle();
    push1(LS, 0, 8'd12);
    #1;
    chk("R6 lock c1 issue0", issue0, 0);
    chk("R6 lock c1 stall", stall, 1);
    next_cycle();
    chk("R6 lock c2 issue0", issue0, 0);
    next_cycle();
    chk("R6 lock c3 issue0", issue0, 0);
    chk("R6 lock c3 stall", stall, 1);
    next_cycle();
    chk("R7 release issue0", issue0, 1);
    chk("R7 release issue1", issue1, 1);
    chk("R7 release tag0", issue_tag0, 11);
    chk("R7 release tag1", issue_tag1, 12);
    drain();
  endtask

  task automatic t_ms_short(input logic [STEP_W-1:0] st);
    push1(MS, st, 8'd20);
    next_cycle();
    push1(EX, 0, 8'd21);
    #1;
    chk("R10 short ms issue0", issue0, 1);
    next_cycle();
    chk("R10 next issue0", issue0, 1);
    chk("R10 next tag0", issue_tag0, 21);
    chk("R10 no stall", stall, 0);
    drain();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    @(negedge clk);
    t_ex_ex();
    @(negedge clk);
    t_pair(EX, LS, 1, "R2 ex-ls");
    @(negedge clk);
    t_pair(LS, EX, 1, "R2 ls-ex");
    @(negedge clk);
    t_pair(LS, LS, 0, "R3 ls-ls");
    @(negedge clk);
    t_pair(EX, MS, 0, "R5 ex-ms");
    @(negedge clk);
    t_dep();
    @(negedge clk);
    t_ms_lock();
    @(negedge clk);
    t_ms_short(3'd1);
    @(negedge clk);
    t_ms_short(3'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule